// File: doc/BRIEF.md
# ADC Result Register Sequencer

This block sits behind an analog-to-digital converter and steers each finished result word into a file of sixteen result registers. It tracks the position of the next write and keeps one valid flag per register. It also signals when a programmed number of conversions, called a sequence, has finished. The converter is represented by a strobe and a data word. Software-facing control arrives as plain inputs: a sequence length code, a FIFO-mode enable, a scan (continuous) enable, a start pulse and an abort pulse.

In normal mode every sequence fills registers from index 0 upward. In FIFO mode the write position keeps running across sequence boundaries and wraps from the last register back to 0, so a continuous scan behaves as a ring buffer. A start or abort always sends the write position back to 0. A read port returns any register's contents. A read can optionally clear that register's valid flag, which lets a consumer track which entries are new. While FIFO mode is on, a compare-disable output tells a neighbouring compare unit to stay off.

Top module: `adc_result_seq`

## Requirements
- R1: After reset, conv_cnt is 0, cc_flags is 0, seq_done is 0 and every register reads 0. The block is already running with an active length of 4, so the 4th accepted result sets seq_done and, with scan off, a 5th strobe is ignored.
- R2: A start loads the active length from seq_len. Code 0 means 16 results and codes 1 to 15 mean that many results. seq_done is set one cycle after the strobe of the final result.
- R3: With fifo_en low, the k-th result of a sequence (counting from 0) is stored in register k, and conv_cnt returns to 0 after the last result of every sequence.
- R4: With fifo_en high, conv_cnt is not reset at sequence ends. It advances by one per accepted result and wraps from 15 to 0.
- R5: conv_cnt always shows the register index that the next accepted result will be written to.
- R6: start or abort clears conv_cnt, all of cc_flags and seq_done in the next cycle. After an abort, strobes are ignored until the next start.
- R7: A result strobe in the same cycle as start or abort is dropped: no register, flag or counter changes, apart from the clear.
- R8: Bit k of cc_flags is set in the cycle after register k is written, and it stays set until it is cleared.
- R9: With scan_en low, strobes after a completed sequence are ignored. With scan_en high, the next sequence begins at once. The first result of that next sequence clears seq_done, and the last result of that sequence sets it again.
- R10: rd_en together with rd_fast_clr clears cc_flags[rd_idx] in the next cycle. rd_en alone leaves the flags unchanged. A write to the same register in the same cycle wins, and the flag ends up set.
- R11: cmp_disable equals fifo_en at all times.
- R12: rd_data shows the contents of register rd_idx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Converter result strobe |
| res_data | input | 12 | Converter result word |
| seq_len | input | 4 | Sequence length code, loaded on start |
| fifo_en | input | 1 | FIFO (ring) placement mode |
| scan_en | input | 1 | Continuous sequence restart |
| start | input | 1 | Start a new sequence |
| abort | input | 1 | Stop and clear |
| rd_en | input | 1 | Read request |
| rd_idx | input | 4 | Register index for read |
| rd_fast_clr | input | 1 | Clear the read register's flag |
| rd_data | output | 12 | Read data |
| cc_flags | output | 16 | Per-register conversion complete flags |
| conv_cnt | output | 4 | Next write index |
| seq_done | output | 1 | Sequence complete |
| cmp_disable | output | 1 | Compare unit forced off |

## Verification
The hardest state to reach is the FIFO wrap. At least seventeen results must be accepted with no start or abort in between, while scan keeps sequences restarting. A directed run with a length of 3 in FIFO scan mode carries the index past register 15. The other hard case is a read-clear that hits the register being written in the same cycle. A directed collision covers it, and a long random phase uses rare start and abort pulses so that runs stay long and collisions recur.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef int unsigned uint_t;

    localparam uint_t DEF_REGS   = 16;
    localparam uint_t DEF_DATA_W = 12;
    localparam uint_t RESET_SPAN = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic abort;
        logic fifo;
        logic scan;
    } seq_cmd_t;

    // Number of results in one sequence for a length code; code 0 selects the whole file.
    function automatic uint_t seq_span(input uint_t code, input uint_t nreg);
        return (code == 0) ? nreg : code;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter uint_t NREG = DEF_REGS,
    localparam uint_t IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_valid,
    input  logic [IW-1:0] seq_len,
    input  seq_cmd_t      cmd,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic          clr_all,
    output logic          seq_done
);

    seq_state_e    state;
    logic [IW-1:0] len_q;
    logic [IW-1:0] seq_pos;
    logic          last;

    assign clr_all = cmd.start | cmd.abort;
    assign wr_en   = res_valid && (state == SEQ_RUN) && !clr_all;
    assign last    = (uint_t'(seq_pos) + 1) == seq_span(uint_t'(len_q), NREG);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_RUN;
            len_q    <= IW'(RESET_SPAN);
            seq_pos  <= '0;
            wr_idx   <= '0;
            seq_done <= 1'b0;
        end else if (clr_all) begin
            if (cmd.start) len_q <= seq_len;
            state    <= cmd.abort ? SEQ_IDLE : SEQ_RUN;
            seq_pos  <= '0;
            wr_idx   <= '0;
            seq_done <= 1'b0;
        end else if (wr_en) begin
            if (last) begin
                seq_done <= 1'b1;
                seq_pos  <= '0;
                if (!cmd.scan) state <= SEQ_IDLE;
                wr_idx   <= cmd.fifo ? wr_idx + IW'(1) : '0;
            end else begin
                if (seq_pos == '0) seq_done <= 1'b0;
                seq_pos <= seq_pos + IW'(1);
                wr_idx  <= wr_idx + IW'(1);
            end
        end
    end

    a_r6_index_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (wr_idx == '0) && !seq_done);

    a_r3_index_restart: assert property (@(posedge clk) disable iff (rst)
        (wr_en && last && !cmd.fifo) |=> (wr_idx == '0) && seq_done);

    a_r4_fifo_advance: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd.fifo) |=> wr_idx == IW'($past(wr_idx) + IW'(1)));

    a_r9_done_source: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> $past(wr_en));

endmodule

// File: rtl/adc_result_file.sv
module adc_result_file
    import adc_seq_pkg::*;
#(
    parameter uint_t NREG = DEF_REGS,
    parameter uint_t DW   = DEF_DATA_W,
    localparam uint_t IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            clr_all,
    input  logic            rd_clr,
    input  logic [IW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic [NREG-1:0] flags
);

    logic [DW-1:0] regs [NREG];

    assign rd_data = regs[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            flags <= '0;
        end else begin
            if (rd_clr) flags[rd_idx] <= 1'b0;
            if (wr_en)  flags[wr_idx] <= 1'b1;
        end
    end

    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> flags[$past(wr_idx)]);

    a_r6_flags_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> flags == '0);

    a_r10_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !clr_all && !(wr_en && wr_idx == rd_idx)) |=> !flags[$past(rd_idx)]);

endmodule

// File: rtl/adc_result_seq.sv
module adc_result_seq
    import adc_seq_pkg::*;
#(
    parameter uint_t NREG = DEF_REGS,
    parameter uint_t DW   = DEF_DATA_W,
    localparam uint_t IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            res_valid,
    input  logic [DW-1:0]   res_data,
    input  logic [IW-1:0]   seq_len,
    input  logic            fifo_en,
    input  logic            scan_en,
    input  logic            start,
    input  logic            abort,
    input  logic            rd_en,
    input  logic [IW-1:0]   rd_idx,
    input  logic            rd_fast_clr,
    output logic [DW-1:0]   rd_data,
    output logic [NREG-1:0] cc_flags,
    output logic [IW-1:0]   conv_cnt,
    output logic            seq_done,
    output logic            cmp_disable
);

    seq_cmd_t      cmd;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic          clr_all;

    assign cmd = '{start: start, abort: abort, fifo: fifo_en, scan: scan_en};
    assign conv_cnt    = wr_idx;
    assign cmp_disable = fifo_en;

    adc_seq_ctrl #(.NREG(NREG)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .res_valid(res_valid),
        .seq_len  (seq_len),
        .cmd      (cmd),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .clr_all  (clr_all),
        .seq_done (seq_done)
    );

    adc_result_file #(.NREG(NREG), .DW(DW)) u_file (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(res_data),
        .clr_all(clr_all),
        .rd_clr (rd_en && rd_fast_clr),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .flags  (cc_flags)
    );

    a_r7_drop_on_clear: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (start || abort)) |=> (cc_flags == '0) && (conv_cnt == '0));

endmodule

// File: tb/adc_result_seq_tb.sv
module adc_result_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v = 1'b0;
    logic [11:0] d = '0;
    logic [3:0]  sl = '0;
    logic        fe = 1'b0, se = 1'b0, st = 1'b0, ab = 1'b0, re = 1'b0, fc = 1'b0;
    logic [3:0]  ri = '0;
    logic [11:0] rd_data;
    logic [15:0] cc_flags;
    logic [3:0]  conv_cnt;
    logic        seq_done, cmp_disable;

    int checks = 0;
    int errors = 0;

    logic [11:0] m_regs [16];
    logic [15:0] m_flags;
    int          m_cnt, m_pos, m_len;
    bit          m_busy, m_done;

    always #2.5 clk = ~clk;

    adc_result_seq u_dut (
        .clk(clk), .rst(rst), .res_valid(v), .res_data(d), .seq_len(sl),
        .fifo_en(fe), .scan_en(se), .start(st), .abort(ab), .rd_en(re),
        .rd_idx(ri), .rd_fast_clr(fc), .rd_data(rd_data), .cc_flags(cc_flags),
        .conv_cnt(conv_cnt), .seq_done(seq_done), .cmp_disable(cmp_disable)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int span_of(input int code);
        return (code == 0) ? 16 : code;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_regs[i] = '0;
        m_flags = '0; m_cnt = 0; m_pos = 0; m_len = 4; m_busy = 1; m_done = 0;
    endtask

    // One clock: drive, check read path, update model, clock, compare state.
    task automatic step(input bit vi, input logic [11:0] di, input bit sti, input bit abi,
                        input bit rei, input logic [3:0] rii, input bit fci);
        bit last;
        v = vi; d = di; st = sti; ab = abi; re = rei; ri = rii; fc = fci;
        #1;
        chk("R12 rd_data", rd_data, m_regs[rii]);
        chk("R11 cmp_disable", cmp_disable, fe);
        if (sti || abi) begin
            m_cnt = 0; m_pos = 0; m_flags = '0; m_done = 0; m_busy = !abi;
            if (sti) m_len = sl;
        end else begin
            if (rei && fci) m_flags[rii] = 1'b0;
            if (vi && m_busy) begin
                m_regs[m_cnt] = di;
                m_flags[m_cnt] = 1'b1;
                last = (m_pos + 1 == span_of(m_len));
                if (last) begin
                    m_done = 1; m_pos = 0; m_busy = se;
                    m_cnt = fe ? (m_cnt + 1) % 16 : 0;
                end else begin
                    if (m_pos == 0) m_done = 0;
                    m_pos++;
                    m_cnt = (m_cnt + 1) % 16;
                end
            end
        end
        @(posedge clk); #1;
        v = 0; st = 0; ab = 0; re = 0; fc = 0;
        chk("R5 conv_cnt", conv_cnt, m_cnt);
        chk("R8 cc_flags", cc_flags, m_flags);
        chk("R9 seq_done", seq_done, m_done);
    endtask

    task automatic strobe(input logic [11:0] di);
        step(1, di, 0, 0, 0, 4'd0, 0);
    endtask

    task automatic read_reg(input logic [3:0] idx, input bit clr);
        step(0, '0, 0, 0, 1, idx, clr);
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 conv_cnt", conv_cnt, 0);
        chk("R1 cc_flags", cc_flags, 0);
        chk("R1 seq_done", seq_done, 0);
        chk("R1 rd_data", rd_data, 0);
        // R1 reset length 4, then R9 ignore without scan
        for (int i = 0; i < 3; i++) strobe(12'h100 + 12'(i));
        chk("R1 done before 4th", seq_done, 0);
        strobe(12'h103);
        chk("R1 done after 4th", seq_done, 1);
        strobe(12'h1FF);
        chk("R9 ignored strobe flags", cc_flags, 16'h000F);
        chk("R9 ignored strobe cnt", conv_cnt, 0);

        // R3 non-FIFO placement with scan, length 5
        sl = 4'd5; se = 1; fe = 0;
        step(0, '0, 1, 0, 0, 4'd0, 0);
        for (int i = 0; i < 5; i++) strobe(12'h200 + 12'(i));
        chk("R3 cnt restart", conv_cnt, 0);
        strobe(12'h2AA);
        chk("R9 done cleared by next seq", seq_done, 0);
        read_reg(4'd0, 0);
        v = 0; #1;
        ri = 4'd0; #1 chk("R3 reg0 rewritten", rd_data, 12'h2AA);
        ri = 4'd4; #1 chk("R3 reg4 kept", rd_data, 12'h204);

        // R2 code 0 = 16 results
        sl = 4'd0; se = 0;
        step(0, '0, 1, 0, 0, 4'd0, 0);
        for (int i = 0; i < 15; i++) strobe(12'h300 + 12'(i));
        chk("R2 not done at 15", seq_done, 0);
        strobe(12'h30F);
        chk("R2 done at 16", seq_done, 1);
        chk("R2 all flags", cc_flags, 16'hFFFF);

        // R4 FIFO wrap with length 3 and scan
        sl = 4'd3; se = 1; fe = 1;
        step(0, '0, 1, 0, 0, 4'd0, 0);
        for (int i = 0; i < 18; i++) strobe(12'h400 + 12'(i));
        chk("R4 wrapped cnt", conv_cnt, 2);
        ri = 4'd1; #1 chk("R4 reg1 from 17th", rd_data, 12'h411);
        ri = 4'd15; #1 chk("R4 reg15", rd_data, 12'h40F);

        // R6 abort clears and stops acceptance
        step(0, '0, 0, 1, 0, 4'd0, 0);
        chk("R6 cnt after abort", conv_cnt, 0);
        chk("R6 flags after abort", cc_flags, 0);
        strobe(12'h555);
        chk("R6 strobe ignored after abort", cc_flags, 0);

        // R7 strobe coincident with start is dropped
        step(1, 12'h777, 1, 0, 0, 4'd0, 0);
        chk("R7 flags", cc_flags, 0);
        chk("R7 cnt", conv_cnt, 0);
        ri = 4'd0; #1 chk("R7 reg0 unchanged", rd_data, 12'h410);

        // R10 fast clear
        strobe(12'h601); strobe(12'h602);
        read_reg(4'd1, 0);
        chk("R10 plain read keeps flag", cc_flags[1], 1);
        read_reg(4'd1, 1);
        chk("R10 fast clear", cc_flags[1], 0);
        step(1, 12'h603, 0, 0, 1, 4'd2, 1);
        chk("R10 write wins", cc_flags[2], 1);

        // R11
        fe = 0; #1 chk("R11 fifo off", cmp_disable, 0);
        fe = 1; #1 chk("R11 fifo on", cmp_disable, 1);

        // Random phase
        void'($urandom(32'h5EED));
        for (int n = 0; n < 6000; n++) begin
            int r;
            r = $urandom_range(0, 199);
            if (r < 2) begin
                sl = 4'($urandom_range(0, 15));
                fe = 1'($urandom_range(0, 1));
                se = ($urandom_range(0, 3) != 0);
                step(1'($urandom_range(0, 1)), 12'($urandom), 1, 0, 0, 4'd0, 0);
            end else if (r < 3) begin
                step(1'($urandom_range(0, 1)), 12'($urandom), 0, 1, 0, 4'd0, 0);
            end else begin
                step(($urandom_range(0, 2) != 0), 12'($urandom), 0, 0,
                     1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                     1'($urandom_range(0, 1)));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule